// File: doc/BRIEF.md
# Sample Fetch Cycle Stealer

This block steals bus cycles from a processor so that one sample byte can be fetched from memory. The machine's cycles alternate between a get phase and a put phase. A memory fetch by the block may only take place on a get cycle. The processor may come out of reset on either phase, and an input chooses which one. Because of this, the length of the stall depends on the phase on which the steal begins.

The block takes a fetch request, a flag that says whether the processor is reading in the current cycle, and the sample address. It can only halt the processor in a cycle in which the processor is reading. While the processor is halted, it keeps repeating its own read. The block raises the halt, holds it through the stall and the fetch cycle, then releases it. A fetch-done strobe marks the fetch cycle. A request that is pending when a fetch completes waits one cycle, so the processor always gets one cycle between two consecutive fetches.

A second request type halts the processor for a single cycle and makes no fetch. The block also holds a small latch for general-purpose output pins. The latch takes in the processor's pin value only when a put cycle ends, so a value that lasts a single cycle reaches the pins only if it falls on a put cycle.

Top module: `sdma_stealer`

## Requirements
- R1: `phaseGet` is 1 on get cycles and 0 on put cycles. In the first cycle after reset it equals `phaseInit`, and it inverts on every clock edge after that.
- R2: Suppose a fetch starts in a get cycle S, meaning that `cpuHalt` is first high in S. Then `cpuHalt` is high in S, S+1 and S+2, and the fetch takes place in S+2.
- R3: Suppose a fetch starts in a put cycle S. Then `cpuHalt` is high in S through S+3, and the fetch takes place in S+3.
- R4: A halt can begin only in a cycle with `cpuRead`=1. A request that arrives during write cycles starts in the first following cycle with `cpuRead`=1. A request that arrives in a read cycle, with the block idle, starts in that same cycle.
- R5: `fetchDone` and `busGrant` are high for exactly one cycle per fetch. That cycle is a get cycle, and it is the last cycle of the halt. In it, `dmaAddr` holds the `sampleAddr` value of the start cycle. `cpuHalt` is low in the next cycle.
- R6: If a fetch request is raised in the cycle right after a fetch completes, the processor is not halted for that one cycle, and the next fetch starts in the cycle after it.
- R7: A `nudgeReq` halts the processor for exactly one read cycle and makes no fetch (`fetchDone` stays 0). If a fetch request and a nudge request are pending together, the fetch goes first. The nudge halt then comes after the one free cycle that follows the fetch.
- R8: `pinOut` takes the value of `pinLevel` on the clock edge that ends each put cycle and holds it through the next two cycles. A `pinLevel` value that is present only during a get cycle never reaches `pinOut`.
- R9: While `rstN` is low, `cpuHalt`, `busGrant`, `fetchDone` and `pinOut` are 0, and `phaseGet` equals `phaseInit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| phaseInit | input | 1 | Phase of the first cycle after reset (1 = get) |
| fetchReq | input | 1 | Request to fetch one sample byte (a pulse is enough) |
| nudgeReq | input | 1 | Request for a single-cycle halt with no fetch |
| cpuRead | input | 1 | Processor is reading in this cycle |
| sampleAddr | input | ADDR_W | Address of the sample byte |
| pinLevel | input | PIN_W | Processor's output-pin value in this cycle |
| cpuHalt | output | 1 | Halt the processor in this cycle |
| busGrant | output | 1 | The block owns the bus in this cycle |
| dmaAddr | output | ADDR_W | Fetch address, valid while `busGrant` is high |
| fetchDone | output | 1 | One-cycle strobe on the fetch cycle |
| phaseGet | output | 1 | Current phase (1 = get, 0 = put) |
| pinOut | output | PIN_W | Output pins, updated only at the end of a put cycle |

## Verification
`cpuHalt` depends on the inputs of the same cycle, so it is due in the start cycle itself. The fetch is due two or three cycles later, depending on the phase of the start cycle. The bench numbers cycles from the release of reset and works out each start and fetch cycle from the arrival cycle, the number of write cycles and `phaseInit ^ cycle[0]`. It drives inputs on the falling edge and samples just before the next rising edge, checking every output in every cycle. `pinOut` is due one edge after a put cycle, so the bench keeps a one-cycle-delayed model of the pins to compare against.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  // Sequencer states: idle, mandatory second halt cycle, phase alignment, fetch
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_ALIGN = 2'd2,
    ST_FETCH = 2'd3
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capAddr;  // latch the sample address (start cycle of a fetch)
    logic grant;    // bus owned by the fetch in this cycle
  } dpStrobe_t;

endpackage

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fetchReq,
  input  logic       nudgeReq,
  input  logic       cpuRead,
  input  logic       phaseGet,
  output dpStrobe_t  strobe,
  output logic       cpuHalt,
  output logic       fetchDone
);

  seqState_t stQ, stD;
  logic fetchPend, nudgePend, gapQ;
  logic fetchLive, nudgeLive, canStart, startFetch, startNudge;

  assign fetchLive  = fetchPend | fetchReq;
  assign nudgeLive  = nudgePend | nudgeReq;
  // A halt may only open on a read cycle, and never right after a steal
  assign canStart   = (stQ == ST_IDLE) & cpuRead & ~gapQ;
  assign startFetch = canStart & fetchLive;
  assign startNudge = canStart & ~fetchLive & nudgeLive;

  always_comb begin
    stD = stQ;
    case (stQ)
      ST_IDLE:  if (startFetch) stD = ST_HOLD;
      // The cycle after HOLD is a get exactly when HOLD is a put
      ST_HOLD:  stD = phaseGet ? ST_ALIGN : ST_FETCH;
      ST_ALIGN: stD = ST_FETCH;
      ST_FETCH: stD = ST_IDLE;
      default:  stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ       <= ST_IDLE;
      fetchPend <= 1'b0;
      nudgePend <= 1'b0;
      gapQ      <= 1'b0;
    end else begin
      stQ       <= stD;
      fetchPend <= startFetch ? 1'b0 : fetchLive;
      nudgePend <= startNudge ? 1'b0 : nudgeLive;
      gapQ      <= (stQ == ST_FETCH) | startNudge;
    end
  end

  assign cpuHalt        = (stQ != ST_IDLE) | startFetch | startNudge;
  assign fetchDone      = (stQ == ST_FETCH);
  assign strobe.capAddr = startFetch;
  assign strobe.grant   = (stQ == ST_FETCH);

endmodule

// File: rtl/sdma_datapath.sv
module sdma_datapath
  import sdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PIN_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              phaseInit,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] sampleAddr,
  input  logic [PIN_W-1:0]  pinLevel,
  output logic              phaseGet,
  output logic              busGrant,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [PIN_W-1:0]  pinOut
);

  localparam logic [ADDR_W-1:0] ADDR_RST = '0;

  logic              phaseQ;
  logic [ADDR_W-1:0] addrQ;
  logic [PIN_W-1:0]  pinQ;

  // Phase toggles every cycle; alignment chosen while in reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= phaseInit;
    else       phaseQ <= ~phaseQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               addrQ <= ADDR_RST;
    else if (strobe.capAddr) addrQ <= sampleAddr;
  end

  // Pin latch: one slice per pin, loaded at the edge closing a put cycle
  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        pinQ[i] <= 1'b0;
      else if (!phaseQ) pinQ[i] <= pinLevel[i];
    end
  end

  assign phaseGet = phaseQ;
  assign busGrant = strobe.grant;
  assign dmaAddr  = addrQ;
  assign pinOut   = pinQ;

endmodule

// File: rtl/sdma_stealer.sv
module sdma_stealer
  import sdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PIN_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              phaseInit,
  input  logic              fetchReq,
  input  logic              nudgeReq,
  input  logic              cpuRead,
  input  logic [ADDR_W-1:0] sampleAddr,
  input  logic [PIN_W-1:0]  pinLevel,
  output logic              cpuHalt,
  output logic              busGrant,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic              fetchDone,
  output logic              phaseGet,
  output logic [PIN_W-1:0]  pinOut
);

  dpStrobe_t strobe;

  sdma_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fetchReq  (fetchReq),
    .nudgeReq  (nudgeReq),
    .cpuRead   (cpuRead),
    .phaseGet  (phaseGet),
    .strobe    (strobe),
    .cpuHalt   (cpuHalt),
    .fetchDone (fetchDone)
  );

  sdma_datapath #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .phaseInit  (phaseInit),
    .strobe     (strobe),
    .sampleAddr (sampleAddr),
    .pinLevel   (pinLevel),
    .phaseGet   (phaseGet),
    .busGrant   (busGrant),
    .dmaAddr    (dmaAddr),
    .pinOut     (pinOut)
  );

endmodule

// File: rtl/sdma_stealer_chk.sv
module sdma_stealer_chk #(
  parameter int PIN_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuRead,
  input logic             cpuHalt,
  input logic             busGrant,
  input logic             fetchDone,
  input logic             phaseGet,
  input logic [PIN_W-1:0] pinOut
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  p_phase_toggle_r1: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (phaseGet != $past(phaseGet)));

  p_stall_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    fetchDone |-> ($past(cpuHalt) && $past(cpuHalt, 2)));

  p_halt_on_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuHalt) |-> cpuRead);

  p_fetch_on_get_r5: assert property (@(posedge clk) disable iff (!rstN)
    fetchDone |-> (phaseGet && busGrant && cpuHalt));

  p_fetch_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    fetchDone |=> !fetchDone);

  p_release_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    fetchDone |=> !cpuHalt);

  p_pin_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !phaseGet |-> $stable(pinOut));

endmodule

bind sdma_stealer sdma_stealer_chk #(.PIN_W(PIN_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuRead   (cpuRead),
  .cpuHalt   (cpuHalt),
  .busGrant  (busGrant),
  .fetchDone (fetchDone),
  .phaseGet  (phaseGet),
  .pinOut    (pinOut)
);

// File: tb/sdma_stealer_bench.sv
`timescale 1ns/100ps
module sdma_stealer_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        phaseInit;
  logic        fetchReq;
  logic        nudgeReq;
  logic        cpuRead;
  logic [15:0] sampleAddr;
  logic [2:0]  pinLevel;
  logic        cpuHalt, busGrant, fetchDone, phaseGet;
  logic [15:0] dmaAddr;
  logic [2:0]  pinOut;

  int nTests = 0;
  int nFail  = 0;
  int cycCount = 0;

  always #2.5 clk = ~clk;

  sdma_stealer u_sdma_stealer (
    .clk(clk), .rstN(rstN), .phaseInit(phaseInit), .fetchReq(fetchReq),
    .nudgeReq(nudgeReq), .cpuRead(cpuRead), .sampleAddr(sampleAddr),
    .pinLevel(pinLevel), .cpuHalt(cpuHalt), .busGrant(busGrant),
    .dmaAddr(dmaAddr), .fetchDone(fetchDone), .phaseGet(phaseGet),
    .pinOut(pinOut)
  );

  always @(posedge clk) begin
    cycCount++;
    if (cycCount == 150000) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit ph(input bit pi, input int k);
    return pi ^ k[0];
  endfunction

  function automatic logic [15:0] addrOf(input int k);
    return 16'h1000 + 16'(k * 273);
  endfunction

  // Ends at the release of reset: the caller is then in cycle 0
  task automatic doReset(input bit pi);
    @(negedge clk);
    rstN = 1'b0; phaseInit = pi; fetchReq = 1'b0; nudgeReq = 1'b0;
    cpuRead = 1'b1; pinLevel = '0; sampleAddr = '0;
    @(negedge clk);
    #1;
    check(cpuHalt == 1'b0,   "R9", "cpuHalt in reset",   cpuHalt, 0);
    check(fetchDone == 1'b0, "R9", "fetchDone in reset", fetchDone, 0);
    check(busGrant == 1'b0,  "R9", "busGrant in reset",  busGrant, 0);
    check(pinOut == 3'b000,  "R9", "pinOut in reset",    pinOut, 0);
    check(phaseGet == pi,    "R9", "phaseGet in reset",  phaseGet, pi);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // One fetch request arriving in cycle arr, wr write cycles from arr on,
  // optionally a second request in the free cycle after the first fetch
  task automatic runFetch(input bit pi, input int arr, input int wr, input bit b2b);
    int s1, f1, s2, f2, last;
    string t;
    s1 = arr + wr;
    f1 = s1 + (ph(pi, s1) ? 2 : 3);
    s2 = f1 + 2;
    f2 = s2 + (ph(pi, s2) ? 2 : 3);
    last = b2b ? f2 + 3 : f1 + 3;
    t = b2b ? "R6" : (wr > 0 ? "R4" : (ph(pi, s1) ? "R2" : "R3"));
    doReset(pi);
    for (int k = 0; k <= last; k++) begin
      bit expH, expD;
      if (k > 0) @(negedge clk);
      fetchReq   = (k == arr) || (b2b && k == f1 + 1);
      cpuRead    = !(k >= arr && k < arr + wr);
      sampleAddr = addrOf(k);
      #1;
      expH = (k >= s1 && k <= f1) || (b2b && k >= s2 && k <= f2);
      expD = (k == f1) || (b2b && k == f2);
      check(cpuHalt == expH,   t,    "cpuHalt",   cpuHalt, expH);
      check(fetchDone == expD, "R5", "fetchDone", fetchDone, expD);
      check(busGrant == expD,  "R5", "busGrant",  busGrant, expD);
      check(phaseGet == ph(pi, k), "R1", "phaseGet", phaseGet, ph(pi, k));
      if (expD)
        check(dmaAddr == addrOf(k == f1 ? s1 : s2), "R5", "dmaAddr",
              dmaAddr, addrOf(k == f1 ? s1 : s2));
    end
    fetchReq = 1'b0;
  endtask

  // Nudge in cycle 1 (possibly during a write), optionally with a fetch
  task automatic runNudge(input bit pi, input int wr, input bit both);
    int s, f, nh;
    s  = 1 + wr;
    f  = s + (ph(pi, s) ? 2 : 3);
    nh = both ? f + 2 : s;
    doReset(pi);
    for (int k = 0; k <= nh + 3; k++) begin
      bit expH, expD;
      if (k > 0) @(negedge clk);
      nudgeReq = (k == 1);
      fetchReq = both && (k == 1);
      cpuRead  = !(k >= 1 && k < 1 + wr);
      sampleAddr = addrOf(k);
      #1;
      expH = (k == nh) || (both && k >= s && k <= f);
      expD = both && (k == f);
      check(cpuHalt == expH,   "R7", "cpuHalt",   cpuHalt, expH);
      check(fetchDone == expD, "R7", "fetchDone", fetchDone, expD);
    end
    nudgeReq = 1'b0;
    fetchReq = 1'b0;
  endtask

  // One-cycle pin pulse in cycle pos
  task automatic runPin(input bit pi, input int pos);
    logic [2:0] expPin;
    expPin = 3'b000;
    doReset(pi);
    for (int k = 0; k <= 10; k++) begin
      if (k > 0) @(negedge clk);
      pinLevel = (k == pos) ? 3'b101 : 3'b000;
      #1;
      check(pinOut == expPin, "R8", "pinOut", pinOut, expPin);
      if (!ph(pi, k)) expPin = pinLevel;
    end
    pinLevel = 3'b000;
  endtask

  initial begin
    rstN = 1'b0; phaseInit = 1'b0; fetchReq = 1'b0; nudgeReq = 1'b0;
    cpuRead = 1'b1; pinLevel = '0; sampleAddr = '0;
    for (int pi = 0; pi < 2; pi++)
      for (int arr = 0; arr < 4; arr++)
        for (int wr = 0; wr < 3; wr++)
          for (int b = 0; b < 2; b++)
            runFetch(pi[0], arr, wr, b[0]);
    for (int pi = 0; pi < 2; pi++)
      for (int wr = 0; wr < 2; wr++)
        for (int b = 0; b < 2; b++)
          runNudge(pi[0], wr, b[0]);
    for (int pi = 0; pi < 2; pi++)
      for (int pos = 1; pos < 6; pos++)
        runPin(pi[0], pos);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule